// File: doc/BRIEF.md
# Snooping MESI Line Coherence Controller

This block keeps the coherence state of every line in a small direct-mapped cache attached to a shared snooping bus. A processor port accepts single-word reads and writes under a valid/ready handshake. A bus-master port issues read-shared, read-exclusive and write-back requests and holds each request until the bus responder answers. A separate snoop port watches the transactions of other masters and answers in the same cycle: it reports whether this cache holds a copy, and it supplies the line when that copy is dirty.

Every line carries one of four states: Modified, Exclusive, Shared or Invalid. A line fetched with no other sharer becomes Exclusive, so a later write to it changes the state to Modified without any bus traffic. The tag and state storage has two read ports. One serves processor lookups and the other serves snoop lookups, so a snoop stalls the processor only when both touch the same line index in the same cycle.

An address splits into a line index (the low `IDXW` bits) and a tag (the remaining upper bits). Each line holds one data word. On a miss or an upgrade, the controller installs the line and then looks it up again. The processor access therefore always completes as a hit.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpuReady` and `busReqValid` are low while no request is pending, and a snoop to any address reports no copy.
- R2: A read miss issues a read-shared request (`busReqCmd` = 1). The line is installed Exclusive when `busRespShared` is low and Shared when it is high, and the read returns the fetched word.
- R3: A processor write to an Exclusive line completes with no bus request and leaves the line Modified.
- R4: A write that misses, or that finds the line Shared, first issues a read-exclusive request (`busReqCmd` = 2). The write then completes and leaves the line Modified.
- R5: A snooped read (`snpExcl` = 0) that hits a Modified line raises `snpIntervene` and `snpShared`, drives the line word on `snpData`, and leaves the line Shared.
- R6: A snooped read that hits an Exclusive line raises `snpShared` but not `snpIntervene`, and leaves the line Shared.
- R7: A snooped intent-to-write (`snpExcl` = 1) that hits a line leaves it Invalid. When the line was Modified, `snpIntervene` is raised and `snpData` carries the line word.
- R8: A snoop whose tag does not match a valid line raises neither `snpShared` nor `snpIntervene`.
- R9: A miss that replaces a Modified line first issues a write-back (`busReqCmd` = 3) with the victim's address and word, and only then issues the fetch.
- R10: `cpuReady` stays low while a bus transaction for the pending request is in progress. On the cycle `cpuReady` is high, `cpuRdata` holds the word of the addressed line.
- R11: A bus request keeps its command, address and data stable until the cycle `busRespValid` is high.
- R12: A snoop to a different index does not stall a processor hit. A snoop to the same index holds `cpuReady` low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | AW | Processor word address |
| cpuWdata | input | DW | Processor write word |
| cpuReady | output | 1 | Request accepted this cycle |
| cpuRdata | output | DW | Read word, valid with cpuReady |
| busReqValid | output | 1 | Bus request pending |
| busReqCmd | output | 2 | 1 read-shared, 2 read-exclusive, 3 write-back |
| busReqAddr | output | AW | Bus request address |
| busReqData | output | DW | Write-back word |
| busRespValid | input | 1 | One-cycle completion of the pending request |
| busRespData | input | DW | Fetched word |
| busRespShared | input | 1 | Another cache holds a copy |
| snpValid | input | 1 | Snooped transaction present |
| snpExcl | input | 1 | 1 = intent to write, 0 = read |
| snpAddr | input | AW | Snooped address |
| snpShared | output | 1 | This cache holds a copy (snooped reads) |
| snpIntervene | output | 1 | This cache supplies dirty data |
| snpData | output | DW | Supplied line word |

## Verification
On every cycle, the assertions check the following:
- a bus request holds steady until it is answered;
- a write-back is always followed by a fetch;
- the processor is never released while a request is on the bus;
- a line reaches Modified only from Exclusive;
- a snoop only lowers a line's rights;
- intervention occurs only for a snooped Modified line.

Only the bench scenarios can show which state a fetch installs, and that written-back and intervened words reach memory intact. The same holds for the exact order of write-back and fetch on eviction, and for the stall caused by a snoop to the same index.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } lineState_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RDS  = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_WB   = 2'd3
  } busCmd_e;

  typedef struct packed {
    logic       cpuStateWr;
    lineState_e cpuStateNew;
    logic       tagWr;
    logic       dataWr;
    logic       dataFromBus;
    logic       snpStateWr;
    lineState_e snpStateNew;
  } ctrlStrobe_t;

endpackage

// File: rtl/mesi_datapath.sv
module mesi_datapath
  import mesi_pkg::*;
#(
  parameter int IDXW = 3,
  parameter int TAGW = 9,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strb,
  input  logic [IDXW-1:0] cpuIdx,
  input  logic [TAGW-1:0] cpuTag,
  input  logic [DW-1:0]   cpuWdata,
  input  logic [DW-1:0]   busData,
  input  logic [IDXW-1:0] snpIdx,
  output lineState_e      stA,
  output logic [TAGW-1:0] tagA,
  output logic [DW-1:0]   dataA,
  output lineState_e      stB,
  output logic [TAGW-1:0] tagB,
  output logic [DW-1:0]   dataB
);

  localparam int LINES = 1 << IDXW;

  lineState_e      stateQ [LINES];
  logic [TAGW-1:0] tagQ   [LINES];
  logic [DW-1:0]   dataQ  [LINES];

  // Processor-side read port
  assign stA   = stateQ[cpuIdx];
  assign tagA  = tagQ[cpuIdx];
  assign dataA = dataQ[cpuIdx];

  // Snoop-side read port
  assign stB   = stateQ[snpIdx];
  assign tagB  = tagQ[snpIdx];
  assign dataB = dataQ[snpIdx];

  // State writes: the processor-side write is last, so it wins on a shared index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stateQ[i] <= ST_I;
    end else begin
      if (strb.snpStateWr) stateQ[snpIdx] <= strb.snpStateNew;
      if (strb.cpuStateWr) stateQ[cpuIdx] <= strb.cpuStateNew;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.tagWr)  tagQ[cpuIdx]  <= cpuTag;
    if (strb.dataWr) dataQ[cpuIdx] <= strb.dataFromBus ? busData : cpuWdata;
  end

  AST_M_ONLY_FROM_E: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cpuStateWr && strb.cpuStateNew == ST_M) |-> (stA == ST_E)); // R3

  AST_SNOOP_ONLY_DEMOTES: assert property (@(posedge clk) disable iff (!rstN)
    strb.snpStateWr |-> ((strb.snpStateNew == ST_I) ||
                         (strb.snpStateNew == ST_S && (stB == ST_E || stB == ST_M)))); // R6

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int IDXW = 3,
  parameter int TAGW = 9
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cpuValid,
  input  logic            cpuWrite,
  input  logic [IDXW-1:0] cpuIdx,
  input  logic [TAGW-1:0] cpuTag,
  output logic            cpuReady,
  input  lineState_e      stA,
  input  logic [TAGW-1:0] tagA,
  output logic            busReqValid,
  output busCmd_e         busReqCmd,
  output logic            selVictim,
  input  logic            busRespValid,
  input  logic            busRespShared,
  input  logic            snpValid,
  input  logic            snpExcl,
  input  logic [IDXW-1:0] snpIdx,
  input  logic [TAGW-1:0] snpTag,
  input  lineState_e      stB,
  input  logic [TAGW-1:0] tagB,
  output logic            snpShared,
  output logic            snpIntervene,
  output ctrlStrobe_t     strb
);

  typedef enum logic [1:0] {C_IDLE, C_WB, C_FETCH} ctrlState_e;

  ctrlState_e stQ, stNxt;
  busCmd_e    cmdQ, cmdNxt;

  logic hitA, hitB, sameIdx;
  assign hitA    = (stA != ST_I) && (tagA == cpuTag);
  assign hitB    = (stB != ST_I) && (tagB == snpTag);
  assign sameIdx = snpValid && (snpIdx == cpuIdx);

  // Snoop response: answered in the cycle of the snoop
  assign snpShared    = snpValid && hitB && !snpExcl;
  assign snpIntervene = snpValid && hitB && (stB == ST_M);

  always_comb begin
    strb        = '0;
    cpuReady    = 1'b0;
    busReqValid = 1'b0;
    busReqCmd   = BUS_NONE;
    selVictim   = 1'b0;
    stNxt       = stQ;
    cmdNxt      = cmdQ;

    if (snpValid && hitB) begin
      if (snpExcl) begin
        strb.snpStateWr  = 1'b1;
        strb.snpStateNew = ST_I;
      end else if (stB != ST_S) begin
        strb.snpStateWr  = 1'b1;
        strb.snpStateNew = ST_S;
      end
    end

    unique case (stQ)
      C_IDLE: begin
        if (cpuValid && !sameIdx) begin
          if (hitA && !(cpuWrite && stA == ST_S)) begin
            cpuReady = 1'b1;
            if (cpuWrite) begin
              strb.dataWr = 1'b1;
              if (stA == ST_E) begin
                strb.cpuStateWr  = 1'b1;
                strb.cpuStateNew = ST_M;
              end
            end
          end else begin
            cmdNxt = cpuWrite ? BUS_RDX : BUS_RDS;
            stNxt  = (!hitA && stA == ST_M) ? C_WB : C_FETCH;
          end
        end
      end
      C_WB: begin
        busReqValid = 1'b1;
        busReqCmd   = BUS_WB;
        selVictim   = 1'b1;
        if (busRespValid) begin
          strb.cpuStateWr  = 1'b1;
          strb.cpuStateNew = ST_I;
          stNxt            = C_FETCH;
        end
      end
      C_FETCH: begin
        busReqValid = 1'b1;
        busReqCmd   = cmdQ;
        if (busRespValid) begin
          strb.tagWr       = 1'b1;
          strb.dataWr      = 1'b1;
          strb.dataFromBus = 1'b1;
          strb.cpuStateWr  = 1'b1;
          strb.cpuStateNew = (cmdQ == BUS_RDX || !busRespShared) ? ST_E : ST_S;
          stNxt            = C_IDLE;
        end
      end
      default: stNxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ  <= C_IDLE;
      cmdQ <= BUS_NONE;
    end else begin
      stQ  <= stNxt;
      cmdQ <= cmdNxt;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busRespValid) |=> (busReqValid && $stable(busReqCmd))); // R11

  AST_WB_THEN_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqCmd == BUS_WB && busRespValid) |=>
      (busReqValid && busReqCmd != BUS_WB && busReqCmd != BUS_NONE)); // R9

  AST_NO_READY_ON_BUS: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busReqValid); // R10

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int IDXW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuValid,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic          cpuReady,
  output logic [DW-1:0] cpuRdata,
  output logic          busReqValid,
  output logic [1:0]    busReqCmd,
  output logic [AW-1:0] busReqAddr,
  output logic [DW-1:0] busReqData,
  input  logic          busRespValid,
  input  logic [DW-1:0] busRespData,
  input  logic          busRespShared,
  input  logic          snpValid,
  input  logic          snpExcl,
  input  logic [AW-1:0] snpAddr,
  output logic          snpShared,
  output logic          snpIntervene,
  output logic [DW-1:0] snpData
);

  localparam int TAGW = AW - IDXW;

  ctrlStrobe_t     strb;
  lineState_e      stA, stB;
  logic [TAGW-1:0] tagA, tagB;
  logic [DW-1:0]   dataA, dataB;
  busCmd_e         cmd;
  logic            selVictim;

  logic [IDXW-1:0] cpuIdx, snpIdx;
  logic [TAGW-1:0] cpuTag, snpTag;
  assign cpuIdx = cpuAddr[IDXW-1:0];
  assign cpuTag = cpuAddr[AW-1:IDXW];
  assign snpIdx = snpAddr[IDXW-1:0];
  assign snpTag = snpAddr[AW-1:IDXW];

  mesi_ctrl #(.IDXW(IDXW), .TAGW(TAGW)) ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuIdx(cpuIdx), .cpuTag(cpuTag),
    .cpuReady(cpuReady), .stA(stA), .tagA(tagA),
    .busReqValid(busReqValid), .busReqCmd(cmd), .selVictim(selVictim),
    .busRespValid(busRespValid), .busRespShared(busRespShared),
    .snpValid(snpValid), .snpExcl(snpExcl), .snpIdx(snpIdx), .snpTag(snpTag),
    .stB(stB), .tagB(tagB),
    .snpShared(snpShared), .snpIntervene(snpIntervene), .strb(strb)
  );

  mesi_datapath #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW)) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuIdx(cpuIdx), .cpuTag(cpuTag), .cpuWdata(cpuWdata), .busData(busRespData),
    .snpIdx(snpIdx),
    .stA(stA), .tagA(tagA), .dataA(dataA),
    .stB(stB), .tagB(tagB), .dataB(dataB)
  );

  assign busReqCmd  = cmd;
  assign busReqAddr = selVictim ? {tagA, cpuIdx} : cpuAddr;
  assign busReqData = dataA;
  assign cpuRdata   = dataA;
  assign snpData    = snpIntervene ? dataB : '0;

  AST_INTERVENE_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    snpIntervene |-> (snpValid && stB == ST_M && tagB == snpTag)); // R5

  AST_WB_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqCmd == 2'd3 && !busRespValid) |=>
      ($stable(busReqAddr) && $stable(busReqData))); // R11

endmodule

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuReady;
  logic [31:0] cpuRdata;
  logic        busReqValid;
  logic [1:0]  busReqCmd;
  logic [11:0] busReqAddr;
  logic [31:0] busReqData;
  logic        busRespValid, busRespShared;
  logic [31:0] busRespData;
  logic        snpValid = 1'b0, snpExcl = 1'b0;
  logic [11:0] snpAddr = '0;
  logic        snpShared, snpIntervene;
  logic [31:0] snpData;

  always #4 clk = ~clk;

  mesi_line_ctrl uut (.*);

  int total = 0, fails = 0;
  logic [31:0] mem [0:4095];
  logic [1:0]  busLog [0:255];
  logic [11:0] logAddr [0:255];
  int          logCnt = 0;
  logic        respSharedCfg = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bus responder: answers each request on its second cycle
  initial begin
    int waitCnt;
    waitCnt = 0;
    busRespValid = 1'b0; busRespShared = 1'b0; busRespData = '0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h1000_0000 + i;
    forever begin
      @(negedge clk);
      busRespValid = 1'b0;
      if (busReqValid) begin
        waitCnt++;
        if (waitCnt == 2) begin
          waitCnt = 0;
          busRespValid  = 1'b1;
          busRespShared = respSharedCfg;
          if (busReqCmd == 2'd3) mem[busReqAddr] = busReqData;
          else busRespData = mem[busReqAddr];
          busLog[logCnt]  = busReqCmd;
          logAddr[logCnt] = busReqAddr;
          logCnt++;
        end
      end
    end
  end

  task automatic cpuOp(input logic w, input logic [11:0] a, input logic [31:0] d, output logic [31:0] rd);
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = a; cpuWdata = d;
    #1;
    while (!cpuReady) begin
      @(negedge clk); #1;
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuValid = 1'b0;
  endtask

  task automatic snoopOp(input logic x, input logic [11:0] a, input logic eShr, input logic eInt,
                         input logic [31:0] eData, input string req);
    snpValid = 1'b1; snpExcl = x; snpAddr = a;
    #1;
    check(snpShared == eShr, req, {31'b0, snpShared}, {31'b0, eShr});
    check(snpIntervene == eInt, req, {31'b0, snpIntervene}, {31'b0, eInt});
    if (eInt) check(snpData == eData, req, snpData, eData);
    if (snpIntervene) mem[a] = snpData;
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        shr;
    logic [1:0]  cmd0;
    logic [1:0]  cmd1;
    logic [31:0] rdata;
  } vec_t;

  // cmd: 0 none, 1 read-shared, 2 read-exclusive, 3 write-back
  localparam vec_t VECS [8] = '{
    '{1'b0, 12'h010, 32'h0,         1'b0, 2'd1, 2'd0, 32'h1000_0010}, // R1 R2 miss -> E
    '{1'b1, 12'h010, 32'hAAAA_0001, 1'b0, 2'd0, 2'd0, 32'h0},         // R3 silent E->M
    '{1'b0, 12'h010, 32'h0,         1'b0, 2'd0, 2'd0, 32'hAAAA_0001}, // R10 hit data
    '{1'b0, 12'h021, 32'h0,         1'b1, 2'd1, 2'd0, 32'h1000_0021}, // R2 miss -> S
    '{1'b1, 12'h021, 32'hBBBB_0002, 1'b0, 2'd2, 2'd0, 32'h0},         // R4 upgrade from S
    '{1'b1, 12'h032, 32'hCCCC_0003, 1'b0, 2'd2, 2'd0, 32'h0},         // R4 write miss
    '{1'b0, 12'h018, 32'h0,         1'b0, 2'd3, 2'd1, 32'h1000_0018}, // R9 dirty eviction
    '{1'b0, 12'h010, 32'h0,         1'b0, 2'd1, 2'd0, 32'hAAAA_0001}  // R9 written-back word
  };

  initial begin
    logic [31:0] rd;
    int start;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(cpuReady == 1'b0, "R1 ready idle", {31'b0, cpuReady}, 32'd0);
    check(busReqValid == 1'b0, "R1 bus idle", {31'b0, busReqValid}, 32'd0);
    @(negedge clk);
    snoopOp(1'b0, 12'h010, 1'b0, 1'b0, 32'h0, "R1 empty snoop");

    for (int v = 0; v < 8; v++) begin
      start = logCnt;
      respSharedCfg = VECS[v].shr;
      cpuOp(VECS[v].wr, VECS[v].addr, VECS[v].wdata, rd);
      check((logCnt - start) == ((VECS[v].cmd0 != 0) ? 1 : 0) + ((VECS[v].cmd1 != 0) ? 1 : 0),
            $sformatf("R2/R3/R4/R9 vec%0d bus count", v), logCnt - start, 0);
      if (VECS[v].cmd0 != 0) check(busLog[start] == VECS[v].cmd0,
            $sformatf("R2/R4/R9 vec%0d cmd0", v), {30'b0, busLog[start]}, {30'b0, VECS[v].cmd0});
      if (VECS[v].cmd1 != 0) check(busLog[start+1] == VECS[v].cmd1,
            $sformatf("R9 vec%0d cmd1", v), {30'b0, busLog[start+1]}, {30'b0, VECS[v].cmd1});
      if (!VECS[v].wr) check(rd == VECS[v].rdata, $sformatf("R2/R10 vec%0d rdata", v), rd, VECS[v].rdata);
    end
    respSharedCfg = 1'b0;

    // R6: snooped read on E (0x010) -> S, so a write needs read-exclusive
    snoopOp(1'b0, 12'h010, 1'b1, 1'b0, 32'h0, "R6 snoop read E");
    start = logCnt;
    cpuOp(1'b1, 12'h010, 32'hDDDD_0004, rd);
    check(logCnt - start == 1 && busLog[start] == 2'd2, "R6 line left Shared", {30'b0, busLog[start]}, 32'd2);

    // R5: snooped read on M (0x021) -> intervene, then S
    snoopOp(1'b0, 12'h021, 1'b1, 1'b1, 32'hBBBB_0002, "R5 snoop read M");
    start = logCnt;
    cpuOp(1'b1, 12'h021, 32'hEEEE_0005, rd);
    check(logCnt - start == 1 && busLog[start] == 2'd2, "R5 line left Shared", {30'b0, busLog[start]}, 32'd2);

    // R7: intent-to-write on M (0x032) -> intervene, then Invalid
    snoopOp(1'b1, 12'h032, 1'b0, 1'b1, 32'hCCCC_0003, "R7 snoop excl M");
    start = logCnt;
    cpuOp(1'b0, 12'h032, 32'h0, rd);
    check(logCnt - start == 1 && busLog[start] == 2'd1, "R7 line Invalid", {30'b0, busLog[start]}, 32'd1);
    check(rd == 32'hCCCC_0003, "R7 intervened word", rd, 32'hCCCC_0003);

    // R8: tag mismatch on a valid index
    snoopOp(1'b0, 12'h7F0, 1'b0, 1'b0, 32'h0, "R8 snoop miss");
    snoopOp(1'b1, 12'h7F0, 1'b0, 1'b0, 32'h0, "R8 snoop excl miss");

    // R7 clean: E line (0x023) invalidated without data
    cpuOp(1'b0, 12'h023, 32'h0, rd);
    snoopOp(1'b1, 12'h023, 1'b0, 1'b0, 32'h0, "R7 snoop excl E");
    start = logCnt;
    cpuOp(1'b0, 12'h023, 32'h0, rd);
    check(logCnt - start == 1 && busLog[start] == 2'd1, "R7 clean line Invalid", {30'b0, busLog[start]}, 32'd1);

    // R9: write-back address of a dirty victim
    cpuOp(1'b1, 12'h025, 32'h5555_0006, rd); // write miss -> M on index 5
    start = logCnt;
    cpuOp(1'b0, 12'h02D, 32'h0, rd);
    check(busLog[start] == 2'd3 && logAddr[start] == 12'h025, "R9 victim address", {20'b0, logAddr[start]}, 32'h025);
    check(mem[12'h025] == 32'h5555_0006, "R9 victim word", mem[12'h025], 32'h5555_0006);

    // R10/R11: stall during a miss, request held stable
    cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 12'h044;
    #1;
    check(cpuReady == 1'b0, "R10 stall on miss", {31'b0, cpuReady}, 32'd0);
    @(negedge clk); #1;
    check(busReqValid && busReqCmd == 2'd1 && busReqAddr == 12'h044, "R11 request issued",
          {20'b0, busReqAddr}, 32'h044);
    check(cpuReady == 1'b0, "R10 stall during bus", {31'b0, cpuReady}, 32'd0);
    @(negedge clk); #1;
    check(busReqValid && busReqAddr == 12'h044 && busReqCmd == 2'd1, "R11 request held",
          {20'b0, busReqAddr}, 32'h044);
    while (!cpuReady) begin
      @(negedge clk); #1;
    end
    check(cpuRdata == 32'h1000_0044, "R10 read word", cpuRdata, 32'h1000_0044);
    @(negedge clk);

    // R12: snoop to another index does not stall a hit
    snpValid = 1'b1; snpExcl = 1'b0; snpAddr = 12'h7F5;
    #1;
    check(cpuReady == 1'b1, "R12 no stall other index", {31'b0, cpuReady}, 32'd1);
    @(negedge clk);
    snpAddr = 12'h044;
    #1;
    check(cpuReady == 1'b0, "R12 stall same index", {31'b0, cpuReady}, 32'd0);
    check(snpShared == 1'b1, "R12 snoop served", {31'b0, snpShared}, 32'd1);
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    check(cpuReady == 1'b1 && cpuRdata == 32'h1000_0044, "R12 resumes", cpuRdata, 32'h1000_0044);
    @(negedge clk);
    cpuValid = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule